// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Array

This block is a rectangular grid of signed fixed-point multiply-accumulate cells that computes a matrix–vector product. Each cell holds one matrix coefficient in its own register. A full matrix is trickled into the grid one row per cycle through a shift chain. Only one row's worth of coefficient wires crosses the block edge. Once loaded, the coefficients stay put and are reused for every vector that follows, for as long as the load strobe stays low.

Vector elements enter on the left edge, one lane per grid row, and step one cell to the right per cycle. Partial sums step one cell down per cycle, starting from zero at the top row. Each column therefore delivers one complete dot product at its bottom edge. The caller skews the lanes on input, and the results leave skewed by column. Each column has its own valid flag that tracks the input valid through the pipeline. Every cycle the grid performs ROWS×COLS multiply-accumulates while exchanging only ROWS inputs and COLS outputs with the outside.

Top module: `syst_ws_array`

## Requirements
- R1: With coefficients W[r][c] resident, the result of column c for vector x is the exact signed sum over rows r of W[r][c]·x[r]. It appears on `out_data[c*AW +: AW]` in two's complement.
- R2: Element r of a vector is presented on `in_data[r*DW +: DW]` exactly r cycles after element 0. `in_valid` is raised in the same cycle as element 0.
- R3: In each cycle with `load_en` high, grid row 0 captures `load_row`, where lane c is `load_row[c*WW +: WW]`, and every row r>0 captures the coefficients that row r-1 held. After ROWS such cycles, the first row supplied sits in the bottom row (ROWS-1) and the last row supplied sits in row 0.
- R4: While `load_en` is low, the coefficients do not change, whatever `load_row` carries. Any number of vectors computed after one load use the same matrix.
- R5: While `load_en` is high, `in_valid` and `in_data` are ignored. No result is launched for those cycles, and no `out_valid` bit rises on their account.
- R6: `out_valid[c]` is high for exactly one cycle, ROWS+c cycles after a cycle in which `in_valid` was high and `load_en` low. Column c+1 therefore lags column c by one cycle.
- R7: A cycle with `in_valid` low produces no `out_valid` pulse in any column, even when `in_data` is non-zero.
- R8: The accumulator width is AW = DW + WW + ceil(log2(ROWS)). With every operand at the most negative value, the result is exact and does not wrap.
- R9: Reset (`rst_n` low, asynchronous) clears every coefficient, every pipeline register and all `out_valid` bits. Vectors streamed after reset with no reload give results of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | High: shift the coefficient chain by one row |
| load_row | input | COLS*WW | One row of signed coefficients, lane c at bits c*WW |
| in_valid | input | 1 | Marks the cycle that carries element 0 of a vector |
| in_data | input | ROWS*DW | Skewed signed vector elements, lane r at bits r*DW |
| out_valid | output | COLS | Per-column result valid, column c lagging by c cycles |
| out_data | output | COLS*AW | Signed column results, column c at bits c*AW |

## Verification
On every cycle, the embedded properties check three things: the coefficient registers hold while loading is off, each row copies the row above while loading is on, and a zero input leaves a partial sum untouched. They also check that the load strobe blocks result launch and that each column's valid repeats its left neighbour one cycle later. The numeric results, the load order through the chain, the skew-dependent latency, the exact extreme-value sums and the behaviour after a mid-stream reset can only be shown by the bench's scenarios. These scenarios compare streamed vectors against independently computed dot products.

// File: rtl/syst_pkg.sv
package syst_pkg;

    // Operating mode of a single grid cell.
    typedef enum logic {
        CELL_RUN  = 1'b0,
        CELL_LOAD = 1'b1
    } cell_mode_e;

    // Accumulator width: product width plus growth for summing `rows` terms.
    function automatic int acc_width(input int dw, input int ww, input int rows);
        return dw + ww + $clog2(rows);
    endfunction

endpackage

// File: rtl/syst_mac_cell.sv
module syst_mac_cell #(
    parameter int DW = 8,
    parameter int WW = 8,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [WW-1:0] w_in,
    input  logic [DW-1:0] x_in,
    input  logic [AW-1:0] sum_in,
    output logic [WW-1:0] w_out,
    output logic [DW-1:0] x_out,
    output logic [AW-1:0] sum_out
);
    import syst_pkg::*;

    typedef struct packed {
        logic [WW-1:0] w;
        logic [DW-1:0] x;
        logic [AW-1:0] sum;
    } cell_state_t;

    cell_state_t st_d, st_q;
    cell_mode_e  mode;
    logic [AW-1:0] x_ext, w_ext, prod;

    always_comb begin
        mode  = load_en ? CELL_LOAD : CELL_RUN;
        x_ext = {{(AW-DW){x_in[DW-1]}}, x_in};
        w_ext = {{(AW-WW){st_q.w[WW-1]}}, st_q.w};
        prod  = x_ext * w_ext;
        st_d      = st_q;
        st_d.x    = x_in;
        st_d.sum  = sum_in + prod;
        case (mode)
            CELL_LOAD: st_d.w = w_in;
            default:   st_d.w = st_q.w;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign w_out   = st_q.w;
    assign x_out   = st_q.x;
    assign sum_out = st_q.sum;

    // R4: coefficient stays put when not loading
    p_weight_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(w_out));

    // R3: loading copies the value offered by the neighbour above
    p_weight_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (w_out == $past(w_in)));

    // R1: a zero operand contributes nothing to the running sum
    p_zero_input_passes_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (x_in == '0) |=> (sum_out == $past(sum_in)));

endmodule

// File: rtl/syst_valid_pipe.sv
module syst_valid_pipe #(
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             v_in,
    output logic [DEPTH-1:0] stages
);
    typedef struct packed {
        logic [DEPTH-1:0] v;
    } vpipe_state_t;

    vpipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.v[0] = v_in & ~kill;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.v[i] = st_q.v[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stages = st_q.v;

    // R5: no launch while the coefficient chain is shifting
    p_load_blocks_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !stages[0]);

    // R6: an accepted input valid always enters the pipeline
    p_launch_accepted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && !kill) |=> stages[0]);

endmodule

// File: rtl/syst_ws_array.sv
module syst_ws_array #(
    parameter  int ROWS = 4,
    parameter  int COLS = 3,
    parameter  int DW   = 8,
    parameter  int WW   = 8,
    localparam int AW   = syst_pkg::acc_width(DW, WW, ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [COLS*WW-1:0] load_row,
    input  logic               in_valid,
    input  logic [ROWS*DW-1:0] in_data,
    output logic [COLS-1:0]    out_valid,
    output logic [COLS*AW-1:0] out_data
);
    localparam int VDEPTH = ROWS + COLS - 1;

    logic [WW-1:0] w_lnk [ROWS][COLS];
    logic [DW-1:0] x_lnk [ROWS][COLS];
    logic [AW-1:0] s_lnk [ROWS][COLS];
    logic [DW-1:0] lane_x [ROWS];
    logic [VDEPTH-1:0] vstages;

    // Compute data is masked at the edge while the chain shifts.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            lane_x[r] = load_en ? '0 : in_data[r*DW +: DW];
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [WW-1:0] w_src;
            logic [DW-1:0] x_src;
            logic [AW-1:0] s_src;

            if (r == 0) begin : g_top
                assign w_src = load_row[c*WW +: WW];
                assign s_src = '0;
            end else begin : g_inner
                assign w_src = w_lnk[r-1][c];
                assign s_src = s_lnk[r-1][c];
            end

            if (c == 0) begin : g_left
                assign x_src = lane_x[r];
            end else begin : g_right
                assign x_src = x_lnk[r][c-1];
            end

            syst_mac_cell #(.DW(DW), .WW(WW), .AW(AW)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .load_en (load_en),
                .w_in    (w_src),
                .x_in    (x_src),
                .sum_in  (s_src),
                .w_out   (w_lnk[r][c]),
                .x_out   (x_lnk[r][c]),
                .sum_out (s_lnk[r][c])
            );
        end
    end

    syst_valid_pipe #(.DEPTH(VDEPTH)) u_vpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill   (load_en),
        .v_in   (in_valid),
        .stages (vstages)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_out
        assign out_data[c*AW +: AW] = s_lnk[ROWS-1][c];
        assign out_valid[c]         = vstages[ROWS-1+c];
    end

    // Tail values that leave the grid edges without a consumer.
    logic [ROWS*DW-1:0] x_tail;
    logic [COLS*WW-1:0] w_tail;
    for (genvar r = 0; r < ROWS; r++) begin : g_xtail
        assign x_tail[r*DW +: DW] = x_lnk[r][COLS-1];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_wtail
        assign w_tail[c*WW +: WW] = w_lnk[ROWS-1][c];
    end
    logic unused_tails;
    assign unused_tails = ^{x_tail, w_tail, vstages};

    // R6: each column's valid repeats its left neighbour one cycle later
    for (genvar c = 1; c < COLS; c++) begin : g_skew_chk
        p_column_skew_r6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[c] == $past(out_valid[c-1]));
    end

endmodule

// File: tb/sim_syst_ws_array.sv
module sim_syst_ws_array;
    localparam int ROWS = 4;
    localparam int COLS = 3;
    localparam int DW   = 8;
    localparam int WW   = 8;
    localparam int AW   = DW + WW + $clog2(ROWS);
    localparam int NV   = 8;

    // Stimulus table: vectors, their valid bits, two coefficient sets.
    localparam logic signed [DW-1:0] VX [NV][ROWS] = '{
        '{8'sd1,    8'sd2,    8'sd3,    8'sd4},
        '{-8'sd1,   8'sd0,    8'sd5,    -8'sd7},
        '{8'sd127,  8'sd127,  8'sd127,  8'sd127},
        '{8'sd50,   8'sd50,   8'sd50,   8'sd50},
        '{8'sd9,    -8'sd9,   8'sd9,    -8'sd9},
        '{-8'sd128, -8'sd128, -8'sd128, -8'sd128},
        '{8'sd3,    8'sd1,    8'sd4,    8'sd1},
        '{-8'sd5,   8'sd6,    -8'sd7,   8'sd8}
    };
    localparam bit VV [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic signed [WW-1:0] W1 [ROWS][COLS] = '{
        '{8'sd1,  8'sd2,  8'sd3},
        '{-8'sd4, 8'sd5,  -8'sd6},
        '{8'sd7,  -8'sd8, 8'sd9},
        '{8'sd10, 8'sd11, -8'sd12}
    };
    localparam logic signed [WW-1:0] W2 [ROWS][COLS] = '{
        '{-8'sd128, 8'sd0,   8'sd1},
        '{-8'sd128, -8'sd1,  8'sd2},
        '{-8'sd128, 8'sd127, 8'sd3},
        '{-8'sd128, -8'sd2,  8'sd4}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               load_en;
    logic [COLS*WW-1:0] load_row;
    logic               in_valid;
    logic [ROWS*DW-1:0] in_data;
    logic [COLS-1:0]    out_valid;
    logic [COLS*AW-1:0] out_data;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    int     mon_launch = 0;
    bit     mon_armed  = 1'b0;
    string  mon_tag    = "R1";
    int     seen [COLS];
    longint exp_y [NV][COLS];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    syst_ws_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .WW(WW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_row  (load_row),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint wsel(input int set, input int r, input int c);
        if (set == 1) return longint'(W1[r][c]);
        if (set == 2) return longint'(W2[r][c]);
        return 0;
    endfunction

    function automatic longint col_out(input int c);
        logic signed [AW-1:0] v;
        v = out_data[c*AW +: AW];
        return longint'(v);
    endfunction

    // Monitor: samples 5 ns after each rising edge.
    always begin
        @(posedge clk);
        #5;
        for (int c = 0; c < COLS; c++) begin
            if (out_valid[c] === 1'b1) begin
                int idx;
                seen[c]++;
                idx = cyc - mon_launch - ROWS - c;
                if (mon_armed && idx >= 0 && idx < NV && VV[idx]) begin
                    // R1 value, R6 timing via idx
                    chk(mon_tag, col_out(c), exp_y[idx][c]);
                end else begin
                    chk("R6 R5 R7 unexpected valid", 1, 0);
                end
            end
        end
    end

    task automatic clear_seen();
        for (int c = 0; c < COLS; c++) seen[c] = 0;
    endtask

    // R3: rows supplied bottom-first, ROWS cycles of load_en.
    task automatic load_weights(input int set, input bit junk);
        for (int i = 0; i < ROWS; i++) begin
            @(negedge clk);
            load_en = 1'b1;
            for (int c = 0; c < COLS; c++)
                load_row[c*WW +: WW] = WW'(wsel(set, ROWS-1-i, c));
            if (junk) begin
                in_valid = 1'b1;
                in_data  = {ROWS{8'h5B}};
            end
        end
        @(negedge clk);
        load_en  = 1'b0;
        load_row = '0;
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    // R2: skewed injection of the whole table.
    task automatic stream(input int set, input string tag);
        int nvalid = 0;
        for (int k = 0; k < NV; k++) begin
            if (VV[k]) nvalid++;
            for (int c = 0; c < COLS; c++) begin
                exp_y[k][c] = 0;
                for (int r = 0; r < ROWS; r++)
                    exp_y[k][c] += wsel(set, r, c) * longint'(VX[k][r]);
            end
        end
        clear_seen();
        mon_tag = tag;
        @(negedge clk);
        mon_launch = cyc;
        mon_armed  = 1'b1;
        for (int t = 0; t < NV + ROWS - 1; t++) begin
            if (t > 0) @(negedge clk);
            in_valid = (t < NV) ? VV[t] : 1'b0;
            for (int r = 0; r < ROWS; r++) begin
                int k;
                k = t - r;
                in_data[r*DW +: DW] = (k >= 0 && k < NV) ? VX[k][r] : '0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        repeat (ROWS + COLS + 3) @(negedge clk);
        mon_armed = 1'b0;
        // R7 and R6: one pulse per valid vector, none for the gap entry
        for (int c = 0; c < COLS; c++) chk("R7 R6 pulse count", seen[c], nvalid);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        load_en  = 1'b0;
        load_row = '0;
        in_valid = 1'b0;
        in_data  = '0;
        clear_seen();
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset out_valid", longint'(out_valid), 0);
        chk("R9 reset out_data", longint'(out_data), 0);
        rst_n = 1'b1;

        // R3 R1 R2: first matrix
        load_weights(1, 1'b0);
        stream(1, "R1 R2 R3 set1");

        // R4: idle with garbage on load_row and load_en low
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            load_row = {COLS{8'hC3}} ^ (COLS*WW)'(i);
        end
        @(negedge clk);
        load_row = '0;
        stream(1, "R4 reuse set1");

        // R5: inputs during load are ignored
        clear_seen();
        load_weights(2, 1'b1);
        repeat (ROWS + COLS + 3) @(negedge clk);
        for (int c = 0; c < COLS; c++) chk("R5 no valid from load cycles", seen[c], 0);

        // R3 order and R8 extremes with the second matrix
        stream(2, "R3 R8 set2");

        // R9: reset in the middle of a vector
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {ROWS{8'h11}};
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        in_data = '0;
        @(negedge clk);
        chk("R9 async clear valid", longint'(out_valid), 0);
        chk("R9 async clear data", longint'(out_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_seen();
        repeat (ROWS + COLS + 3) @(negedge clk);
        for (int c = 0; c < COLS; c++) chk("R9 no stale valid", seen[c], 0);
        stream(0, "R9 zero weights after reset");

        finish_run();
    end
endmodule